// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a bus fetch engine and an execution unit. While the consumer works on the current instruction, it reads the bytes that follow from memory and keeps them in a small in-order byte queue. The fetch side holds a 20-bit fetch address. It raises a byte read request whenever the queue, together with the reads already issued, leaves room for another byte. Returned bytes enter the queue in the order the reads were issued. The consumer takes bytes only from the head of the queue, and it waits whenever the queue is empty.

A taken branch is signalled with a one-cycle redirect strobe and a target address. The redirect empties the queue at once and loads the fetch address with the target. Any read already issued to memory still returns, but its byte is dropped, so refilling starts cleanly at the new location. Reset also empties the queue, and fetching then begins at a reset vector parameter.

The memory port is a request/grant handshake with in-order responses that arrive some cycles later. A response is a one-cycle valid strobe with a data byte.

Top module: `ifq_prefetch`

## Requirements
- R1: While reset is applied the queue is empty (`deq_valid`=0, `fill_level`=0) and `mem_addr` equals the RESET_VEC parameter (default 20'hFFFF0). Within a few cycles of reset release `mem_req` rises, with `mem_addr` still at RESET_VEC.
- R2: Bytes leave at `deq_data` in the same order their reads were accepted. With `deq_valid` high, `deq_data` is the oldest byte held, and a pop removes exactly that byte.
- R3: When the queue is empty `deq_valid` is low and a pop has no effect. The consumer then waits, and the next byte it receives is the next byte in fetch order.
- R4: `fill_level` never exceeds DEPTH (default 6). `mem_req` stays low while `fill_level` plus the reads still owed to the queue would reach DEPTH, so a full queue issues no requests.
- R5: Each accepted request (`mem_req` and `mem_gnt` high in the same cycle) advances `mem_addr` by one in the following cycle. The address wraps from 20'hFFFFF to 20'h00000.
- R6: A cycle with `redirect` high leaves the queue empty in the next cycle (`fill_level`=0, `deq_valid`=0), with `mem_addr` equal to `redirect_tgt`. `mem_req` is low during the redirect cycle.
- R7: Bytes that return for reads accepted before a redirect are discarded. The first byte delivered after a redirect is the byte at `redirect_tgt`.
- R8: A redirect takes priority over a pop or a returning byte in the same cycle. After such a cycle the queue is empty and delivery restarts at the target.
- R9: At most MAX_OUT (default 2) accepted reads are outstanding, meaning accepted but not yet answered by `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| redirect | input | 1 | Taken-branch strobe: flush the queue and refetch from the target |
| redirect_tgt | input | AW (20) | Branch target fetch address |
| deq_pop | input | 1 | Consumer takes the head byte when deq_valid is high |
| deq_valid | output | 1 | Head byte available |
| deq_data | output | DW (8) | Head byte |
| fill_level | output | clog2(DEPTH+1) (3) | Number of bytes held |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | AW (20) | Address of the requested byte (the fetch address) |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data returned this cycle, in request order |
| mem_rdata | input | DW (8) | Returned byte |

## Verification
The memory model answers every read with a byte computed from its address. The consumer checks each byte against an address it tracks on its own, so a misordered, duplicated, skipped or stale byte appears as a data mismatch. The main flow is tried four ways: with the consumer idle until the queue fills, which separates correct room accounting from overflow or early stall; with continuous draining, which checks order and address stepping; with grants withheld until the queue runs dry, which separates a true stall from reading a stale head; and with redirects placed while reads are in flight, together with a pop, and just below the top of the address space, which separates discarding and redirect priority from leaks of old-stream bytes and from wrong address wrap.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int unsigned IFQ_DEPTH   = 6;
  localparam int unsigned IFQ_AW      = 20;
  localparam int unsigned IFQ_DW      = 8;
  localparam int unsigned IFQ_MAX_OUT = 2;

  // per-cycle queue operations, already qualified by the control logic
  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
  } ifq_ops_t;
endpackage

// File: rtl/ifq_rst_sync.sv
module ifq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/ifq_store.sv
module ifq_store
  import ifq_pkg::*;
#(
  parameter int unsigned DEPTH = IFQ_DEPTH,
  parameter int unsigned DW    = IFQ_DW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ifq_ops_t                     ops,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         valid
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [IW-1:0] rd_idx_q, rd_idx_d;
  logic [IW-1:0] wr_idx_q, wr_idx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en;
  logic [DEPTH-1:0][DW-1:0] slot_q;

  function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] idx);
    return (idx == IW'(DEPTH-1)) ? '0 : idx + 1'b1;
  endfunction

  assign wr_en = ops.push && !ops.flush;

  always_comb begin
    rd_idx_d = rd_idx_q;
    wr_idx_d = wr_idx_q;
    cnt_d    = cnt_q;
    if (ops.flush) begin
      rd_idx_d = '0;
      wr_idx_d = '0;
      cnt_d    = '0;
    end else begin
      if (ops.push) wr_idx_d = step_idx(wr_idx_q);
      if (ops.pop)  rd_idx_d = step_idx(rd_idx_q);
      cnt_d = cnt_q + CW'(ops.push) - CW'(ops.pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx_q <= '0;
      wr_idx_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_idx_q <= rd_idx_d;
      wr_idx_q <= wr_idx_d;
      cnt_q    <= cnt_d;
    end
  end

  // one data register per slot, each with its own write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] data_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx_q == IW'(i))) data_q <= wdata;
    end
    assign slot_q[i] = data_q;
  end

  assign rdata = slot_q[rd_idx_q];
  assign level = cnt_q;
  assign valid = (cnt_q != '0);
endmodule

// File: rtl/ifq_fetch.sv
module ifq_fetch
  import ifq_pkg::*;
#(
  parameter int unsigned       DEPTH     = IFQ_DEPTH,
  parameter int unsigned       AW        = IFQ_AW,
  parameter int unsigned       MAX_OUT   = IFQ_MAX_OUT,
  parameter logic [AW-1:0]     RESET_VEC = 20'hFFFF0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [AW-1:0]              flush_tgt,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic                       mem_gnt,
  input  logic                       mem_rvalid,
  output logic                       mem_req,
  output logic [AW-1:0]              mem_addr,
  output logic                       keep_rsp
);
  localparam int unsigned OW = $clog2(MAX_OUT+1);
  localparam int unsigned SW = $clog2(DEPTH+MAX_OUT+1) + 1;

  logic [AW-1:0] ptr_q, ptr_d;
  logic [OW-1:0] inflight_q, inflight_d;
  logic [OW-1:0] drop_q, drop_d;
  logic          active_q;
  logic [SW-1:0] committed;
  logic          room;
  logic          fire;
  logic          stale_rsp;

  // bytes already held plus reads that will still land in the queue
  assign committed = SW'(level) + SW'(inflight_q - drop_q);
  assign room      = (committed < SW'(DEPTH)) && (inflight_q < OW'(MAX_OUT));
  assign mem_req   = active_q && !flush && room;
  assign fire      = mem_req && mem_gnt;
  assign stale_rsp = mem_rvalid && (drop_q != '0);
  assign keep_rsp  = mem_rvalid && !stale_rsp && !flush;
  assign mem_addr  = ptr_q;

  always_comb begin
    ptr_d      = ptr_q;
    inflight_d = inflight_q + OW'(fire) - OW'(mem_rvalid);
    drop_d     = drop_q;
    if (flush) begin
      ptr_d  = flush_tgt;
      drop_d = inflight_q - OW'(mem_rvalid);
    end else begin
      if (fire)      ptr_d  = ptr_q + 1'b1;
      if (stale_rsp) drop_d = drop_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= RESET_VEC;
      inflight_q <= '0;
      drop_q     <= '0;
      active_q   <= 1'b0;
    end else begin
      ptr_q      <= ptr_d;
      inflight_q <= inflight_d;
      drop_q     <= drop_d;
      active_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch
  import ifq_pkg::*;
#(
  parameter int unsigned       DEPTH     = IFQ_DEPTH,
  parameter int unsigned       AW        = IFQ_AW,
  parameter int unsigned       DW        = IFQ_DW,
  parameter int unsigned       MAX_OUT   = IFQ_MAX_OUT,
  parameter logic [AW-1:0]     RESET_VEC = 20'hFFFF0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       redirect,
  input  logic [AW-1:0]              redirect_tgt,
  input  logic                       deq_pop,
  output logic                       deq_valid,
  output logic [DW-1:0]              deq_data,
  output logic [$clog2(DEPTH+1)-1:0] fill_level,
  output logic                       mem_req,
  output logic [AW-1:0]              mem_addr,
  input  logic                       mem_gnt,
  input  logic                       mem_rvalid,
  input  logic [DW-1:0]              mem_rdata
);
  logic     rst_sync_n;
  logic     keep_rsp;
  ifq_ops_t ops;

  ifq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // a redirect overrides both the consumer pop and any returning byte
  assign ops.flush = redirect;
  assign ops.push  = keep_rsp;
  assign ops.pop   = deq_pop && deq_valid && !redirect;

  ifq_fetch #(
    .DEPTH     (DEPTH),
    .AW        (AW),
    .MAX_OUT   (MAX_OUT),
    .RESET_VEC (RESET_VEC)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush      (redirect),
    .flush_tgt  (redirect_tgt),
    .level      (fill_level),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .keep_rsp   (keep_rsp)
  );

  ifq_store #(
    .DEPTH (DEPTH),
    .DW    (DW)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ops   (ops),
    .wdata (mem_rdata),
    .rdata (deq_data),
    .level (fill_level),
    .valid (deq_valid)
  );
endmodule

// File: rtl/ifq_prefetch_chk.sv
module ifq_prefetch_chk #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned AW    = 20
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       redirect,
  input logic [AW-1:0]              redirect_tgt,
  input logic                       deq_valid,
  input logic [$clog2(DEPTH+1)-1:0] fill_level,
  input logic                       mem_req,
  input logic                       mem_gnt,
  input logic [AW-1:0]              mem_addr,
  input logic                       mem_rvalid
);
  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= ($clog2(DEPTH+1))'(DEPTH));

  a_r4_full_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == ($clog2(DEPTH+1))'(DEPTH)) |-> !mem_req);

  a_r3_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0 && !mem_rvalid) |=> (fill_level == '0 && !deq_valid));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  a_r6_redirect_empties: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (fill_level == '0 && !deq_valid));

  a_r6_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (mem_addr == $past(redirect_tgt)));

  a_r6_no_req_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !mem_req);
endmodule

bind ifq_prefetch ifq_prefetch_chk #(
  .DEPTH (DEPTH),
  .AW    (AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .redirect     (redirect),
  .redirect_tgt (redirect_tgt),
  .deq_valid    (deq_valid),
  .fill_level   (fill_level),
  .mem_req      (mem_req),
  .mem_gnt      (mem_gnt),
  .mem_addr     (mem_addr),
  .mem_rvalid   (mem_rvalid)
);

// File: tb/ifq_prefetch_bench.sv
module ifq_prefetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;
  localparam int MAX_OUT    = 2;
  localparam logic [19:0] RVEC = 20'hFFFF0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        redirect;
  logic [19:0] redirect_tgt;
  logic        deq_pop;
  logic        deq_valid;
  logic [7:0]  deq_data;
  logic [2:0]  fill_level;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_gnt;
  logic        mem_rvalid;
  logic [7:0]  mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [19:0] exp_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifq_prefetch u_ifq_prefetch (
    .clk (clk), .rst_n (rst_n),
    .redirect (redirect), .redirect_tgt (redirect_tgt),
    .deq_pop (deq_pop), .deq_valid (deq_valid), .deq_data (deq_data),
    .fill_level (fill_level),
    .mem_req (mem_req), .mem_addr (mem_addr), .mem_gnt (mem_gnt),
    .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction

  // memory model: fixed two-edge latency, in-order answers
  logic        p_v;
  logic [19:0] p_a;
  int          out_cnt = 0;
  int          out_max = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      p_v        <= 1'b0;
      p_a        <= '0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      out_cnt     = 0;
    end else begin
      out_cnt = out_cnt + ((mem_req && mem_gnt) ? 1 : 0) - (mem_rvalid ? 1 : 0);
      if (out_cnt > out_max) out_max = out_cnt;
      p_v        <= mem_req && mem_gnt;
      p_a        <= mem_addr;
      mem_rvalid <= p_v;
      mem_rdata  <= mem_byte(p_a);
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // wait for a head byte, check it against the tracked address, pop it
  task automatic pop_check(input string rq);
    int w = 0;
    @(negedge clk);
    while (!deq_valid && w < 100) begin
      @(negedge clk);
      w++;
    end
    chk(deq_valid && deq_data == mem_byte(exp_addr), rq,
        {23'd0, deq_valid, deq_data}, {24'd1, mem_byte(exp_addr)});
    deq_pop = 1'b1;
    @(negedge clk);
    deq_pop = 1'b0;
    exp_addr = exp_addr + 1'b1;
  endtask

  task automatic do_redirect(input logic [19:0] tgt, input bit with_pop,
                             input string rq);
    @(negedge clk);
    redirect     = 1'b1;
    redirect_tgt = tgt;
    deq_pop      = with_pop;
    @(negedge clk);
    redirect = 1'b0;
    deq_pop  = 1'b0;
    chk(fill_level == 0 && !deq_valid, rq, {28'd0, deq_valid, fill_level}, 32'd0);
    chk(mem_addr == tgt, rq, {12'd0, mem_addr}, {12'd0, tgt});
    exp_addr = tgt;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    redirect = 1'b0; redirect_tgt = '0; deq_pop = 1'b0; mem_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(!deq_valid && fill_level == 0, "R1 reset empty",
        {28'd0, deq_valid, fill_level}, 32'd0);
    chk(mem_addr == RVEC, "R1 reset vector", {12'd0, mem_addr}, {12'd0, RVEC});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem_req && mem_addr == RVEC, "R1 first request",
        {11'd0, mem_req, mem_addr}, {11'd1, RVEC});
    exp_addr = RVEC;
    mem_gnt  = 1'b1;
  endtask

  task automatic t_fill();
    repeat (30) @(negedge clk);
    chk(fill_level == 3'(DEPTH), "R4 fills to depth", {29'd0, fill_level}, DEPTH);
    chk(!mem_req, "R4 no request when full", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_drain();
    for (int i = 0; i < 12; i++) pop_check("R2 R5 in-order stream");
  endtask

  task automatic t_empty_stall();
    mem_gnt = 1'b0;
    repeat (6) @(negedge clk);
    while (deq_valid) pop_check("R2 drain before stall");
    repeat (3) @(negedge clk);
    deq_pop = 1'b1;
    repeat (3) @(negedge clk);
    deq_pop = 1'b0;
    chk(fill_level == 0 && !deq_valid, "R3 pop on empty ignored",
        {28'd0, deq_valid, fill_level}, 32'd0);
    mem_gnt = 1'b1;
    pop_check("R3 byte after stall");
    pop_check("R3 byte after stall");
  endtask

  task automatic t_redirect_inflight();
    repeat (10) @(negedge clk);
    pop_check("R2 before redirect");
    pop_check("R2 before redirect");
    do_redirect(20'h12345, 1'b0, "R6 redirect empties");
    for (int i = 0; i < 8; i++) pop_check("R7 stale bytes dropped");
  endtask

  task automatic t_redirect_pop();
    repeat (10) @(negedge clk);
    chk(deq_valid, "R8 queue holds bytes", {31'd0, deq_valid}, 32'd1);
    do_redirect(20'h0A5C3, 1'b1, "R8 redirect beats pop");
    pop_check("R8 first byte at target");
    pop_check("R8 second byte at target");
  endtask

  task automatic t_wrap();
    do_redirect(20'hFFFFE, 1'b0, "R6 redirect near top");
    for (int i = 0; i < 5; i++) pop_check("R5 address wraps");
    chk(exp_addr == 20'h00003, "R5 wrap count", {12'd0, exp_addr}, 32'h3);
  endtask

  task automatic t_outstanding();
    chk(out_max <= MAX_OUT && out_max > 0, "R9 outstanding bound", out_max, MAX_OUT);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_drain();
    t_empty_stall();
    t_redirect_inflight();
    t_redirect_pop();
    t_wrap();
    t_outstanding();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule